// File: doc/BRIEF.md
# Analog Memory Column Acquisition Controller

This controller runs the acquisition and conversion phases of a 64-channel front-end whose analog sample memory holds 15 columns. An acquisition window is opened by holding the start input high. Inside the window, each accepted trigger writes the channel hit flags and the current bunch-crossing count into the next free column. A discard input, asserted in the cycle after a trigger, throws that column away so that it can be reused.

When the start input falls, a single busy line rises. This tells the outside controller that conversion may begin. The block then steps through the filled columns in order, presenting each column's contents and waiting for one ADC-done pulse per column. Busy falls when the last column has been converted, and every chip that shares this handshake behaves the same way. If nothing was stored, busy is high for a single cycle.

Top module: `amem_acq_ctrl`

## Requirements
- R1: After reset, `busy_o`, `full_o`, `ncol_o` and `conv_col_o` are all 0.
- R2: In acquisition with `acq_i` high, a trigger sampled at a clock edge while no column is pending and `ncol_o` < 15 is accepted. It stores `hits_i` and the bunch-crossing count into column `ncol_o`. The column is pending for one cycle, and `ncol_o` increments at the next edge. Triggers that arrive while a column is pending are ignored.
- R3: If `notrig_i` is high at the edge that follows an accepted trigger, the pending column is discarded and `ncol_o` does not change. `notrig_i` at any other time has no effect.
- R4: When `ncol_o` reaches 15, `full_o` is 1 and further triggers do not change `ncol_o`.
- R5: The bunch-crossing count is 12 bits wide. If `acq_i` is first sampled high at edge A, a trigger accepted at edge A+n (n ≥ 1) stores the value n−1.
- R6: Acquisition is level-sensitive. It lasts while `acq_i` is sampled high. At the first edge where `acq_i` is low and no column is pending, `busy_o` goes to 1.
- R7: If no column was stored, `busy_o` stays high for exactly one cycle.
- R8: During conversion, `conv_col_o` starts at 0 and `conv_hits_o`/`conv_bcid_o` show that column. Each `adc_done_i` moves to the next column. `busy_o` falls at the edge that samples `adc_done_i` for the last column. `adc_done_i` outside conversion is ignored.
- R9: `acq_i`, `trig_i` and `notrig_i` are ignored during conversion. `ncol_o` is 0 after conversion ends, and a new acquisition can then start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_i | input | 1 | Start-acquisition level |
| trig_i | input | 1 | Trigger request |
| notrig_i | input | 1 | Discard the pending column |
| hits_i | input | 64 | Channel hit flags for the trigger |
| adc_done_i | input | 1 | One column converted |
| busy_o | output | 1 | Conversion busy handshake |
| full_o | output | 1 | All columns filled |
| ncol_o | output | 4 | Number of stored columns |
| conv_col_o | output | 4 | Column under conversion |
| conv_hits_o | output | 64 | Hit flags of that column |
| conv_bcid_o | output | 12 | Bunch-crossing count of that column |

## Verification
The assertions assume the inputs come from a well-behaved driver. `adc_done_i` is a single-cycle pulse. `notrig_i` only means something in the cycle after a trigger. `acq_i` is low long enough for the block to leave conversion before a new window is wanted. The bench drives every input one time unit after a rising edge. It sweeps the trigger count from 0 to beyond the memory depth, and it discards columns with a fixed arithmetic pattern. It raises `acq_i` and `trig_i` during conversion only on runs that test that those inputs are ignored, and it lowers them again before the block returns to idle.

// File: rtl/amem_acq_ctrl.sv
module amem_acq_ctrl #(
  parameter int NCH   = 64,
  parameter int DEPTH = 15,
  parameter int BCW   = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acq_i,
  input  logic                         trig_i,
  input  logic                         notrig_i,
  input  logic [NCH-1:0]               hits_i,
  input  logic                         adc_done_i,
  output logic                         busy_o,
  output logic                         full_o,
  output logic [$clog2(DEPTH+1)-1:0]   ncol_o,
  output logic [$clog2(DEPTH+1)-1:0]   conv_col_o,
  output logic [NCH-1:0]               conv_hits_o,
  output logic [BCW-1:0]               conv_bcid_o
);
  localparam int CW = $clog2(DEPTH+1);

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_CONV} state_t;

  state_t          state;
  logic [CW-1:0]   ncol, conv_col;
  logic            pend;
  logic [BCW-1:0]  bcid;
  logic [NCH-1:0]  hit_mem [DEPTH];
  logic [BCW-1:0]  bc_mem  [DEPTH];

  wire full   = (ncol == CW'(DEPTH));
  wire accept = (state == S_ACQ) && acq_i && trig_i && !pend && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ncol     <= '0;
      conv_col <= '0;
      pend     <= 1'b0;
      bcid     <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          bcid     <= '0;
          pend     <= 1'b0;
          conv_col <= '0;
          if (acq_i) state <= S_ACQ;
        end
        S_ACQ: begin
          bcid <= bcid + 1'b1;
          if (pend) begin
            pend <= 1'b0;
            if (!notrig_i) ncol <= ncol + 1'b1;
          end else if (accept) begin
            pend <= 1'b1;
          end
          if (!acq_i && !pend) begin
            state    <= S_CONV;
            conv_col <= '0;
          end
        end
        S_CONV: begin
          if (ncol == '0) begin
            state <= S_IDLE;
          end else if (adc_done_i) begin
            if (conv_col == ncol - CW'(1)) begin
              state <= S_IDLE;
              ncol  <= '0;
            end else begin
              conv_col <= conv_col + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      hit_mem[ncol] <= hits_i;
      bc_mem[ncol]  <= bcid;
    end
  end

  assign busy_o      = (state == S_CONV);
  assign full_o      = full;
  assign ncol_o      = ncol;
  assign conv_col_o  = conv_col;
  assign conv_hits_o = (conv_col < CW'(DEPTH)) ? hit_mem[conv_col] : '0;
  assign conv_bcid_o = (conv_col < CW'(DEPTH)) ? bc_mem[conv_col]  : '0;

  p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACQ && pend && !notrig_i) |=> ncol_o == $past(ncol_o) + 1'b1);

  p_erase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACQ && pend && notrig_i) |=> $stable(ncol_o));

  p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACQ && full_o) |=> ($stable(ncol_o) && full_o));

  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACQ && !acq_i && !pend) |=> busy_o);

  p_empty_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ncol_o == '0) |=> !busy_o);

  p_wait_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ncol_o != '0 && !adc_done_i) |=> ($stable(conv_col_o) && busy_o));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (ncol_o == '0));
endmodule

// File: tb/amem_acq_ctrl_tb.sv
module amem_acq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 64, DEPTH = 15, BCW = 12;

  logic clk = 0, rst_n = 0;
  logic acq_i = 0, trig_i = 0, notrig_i = 0, adc_done_i = 0;
  logic [NCH-1:0] hits_i = '0;
  logic busy_o, full_o;
  logic [3:0] ncol_o, conv_col_o;
  logic [NCH-1:0] conv_hits_o;
  logic [BCW-1:0] conv_bcid_o;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [NCH-1:0] exp_hits [DEPTH];
  logic [BCW-1:0] exp_bc   [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  amem_acq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .trig_i(trig_i), .notrig_i(notrig_i),
    .hits_i(hits_i), .adc_done_i(adc_done_i), .busy_o(busy_o), .full_o(full_o),
    .ncol_o(ncol_o), .conv_col_o(conv_col_o), .conv_hits_o(conv_hits_o),
    .conv_bcid_o(conv_bcid_o)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(int att);
    int n = 0;
    int e = 0;
    acq_i = 1;
    step();
    for (int i = 0; i < att; i++) begin
      logic [NCH-1:0] pat = {32'(att * 7 + i * 3 + 1), ~32'(i * 13 + att)};
      bit erase = ((i * 5 + att) % 7) == 6;
      trig_i = 1; hits_i = pat;
      if (n < DEPTH) begin exp_hits[n] = pat; exp_bc[n] = BCW'(e); end
      step(); e++;
      trig_i = 0; hits_i = '0;
      chk("R2 pending", ncol_o, n);
      notrig_i = erase;
      step(); e++;
      notrig_i = 0;
      if (n < DEPTH && !erase) n++;
      chk(erase ? "R3 erase" : "R2 commit", ncol_o, n);
      chk("R4 full", full_o, n == DEPTH);
      for (int g = 0; g < i % 3; g++) begin
        adc_done_i = 1; notrig_i = (g == 1);
        step(); e++;
        adc_done_i = 0; notrig_i = 0;
      end
      chk("R8 done ignored in acq", ncol_o, n);
    end
    chk("R6 no busy during acq", busy_o, 0);
    acq_i = 0;
    step();
    chk("R6 busy rise", busy_o, 1);
    if (n == 0) begin
      step();
      chk("R7 empty pulse", busy_o, 0);
    end else begin
      for (int c = 0; c < n; c++) begin
        chk("R8 col", conv_col_o, c);
        chk("R8 hits", conv_hits_o, exp_hits[c]);
        chk("R5 bcid", conv_bcid_o, exp_bc[c]);
        if (att % 2 == 1) begin acq_i = 1; trig_i = 1; notrig_i = 1; end
        step();
        chk("R8 wait", {busy_o, conv_col_o}, {1'b1, 4'(c)});
        adc_done_i = 1;
        step();
        adc_done_i = 0; acq_i = 0; trig_i = 0; notrig_i = 0;
        if (c < n - 1) chk("R9 busy held", busy_o, 1);
      end
      chk("R8 busy fall", busy_o, 0);
    end
    step();
    chk("R9 cleared", {busy_o, full_o, ncol_o}, 6'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R1 reset", {busy_o, full_o, ncol_o, conv_col_o}, 10'd0);
    rst_n = 1;
    step();
    chk("R1 idle", {busy_o, full_o, ncol_o}, 6'd0);
    for (int att = 0; att <= 19; att++) run(att);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule